// File: doc/BRIEF.md
# Monitor-Wait Address Watch Unit

This unit lets a processor core sleep until another agent writes to one cache line. The core first issues an arm command with a virtual address. The unit keeps that address and offers a small probe access toward it. The core then issues a wait command with the translated physical address. The unit strips the line-offset bits from that address, keeps the resulting line as the watched line and raises a halt request toward the core.

The coherence side presents invalidation addresses on a snoop port. A snoop that hits the watched line, while the unit is both armed and waiting, ends the wait. The halt request drops and a single-cycle wake pulse is sent. Each wake also sets a sticky pending flag. The next wait command consumes that flag and does not halt. A write that lands between arming and waiting therefore still stops the core from sleeping.

Top module: `mw_watch_unit`

## Requirements
- R1: After reset, halt_req and wake are low and watch_line is zero.
- R2: An arm command, one cycle later, shows its virtual address on probe_addr and sets watch_line to zero. It does not change halt_req.
- R3: A wait command with no pending wakeup, one cycle later, sets watch_line to wait_paddr with its low log2(LINE_BYTES) bits cleared and raises halt_req. halt_req then stays high until a wake.
- R4: A wait command while a wakeup is pending clears the pending flag. It leaves halt_req low and watch_line unchanged, so the next wait command halts normally.
- R5: A snoop hits only when the unit is armed and waiting and snoop_addr equals watch_line exactly. A hit, one cycle later, drives wake high and halt_req low.
- R6: Every wake sets the pending flag, so the first wait command after any wake is cancelled.
- R7: wake is high for exactly one cycle per hit.
- R8: A snoop that does not hit changes nothing: no wake, and halt_req and watch_line keep their values. This covers a snoop while unarmed, a snoop while not waiting, a snoop to another line and a snoop with non-zero offset bits.
- R9: probe_size equals the smaller of PROBE_BYTES (8) and LINE_BYTES minus the line offset of probe_addr, so the probe never crosses into the next line.
- R10: When a hitting snoop and a wait command arrive in the same cycle, the snoop is applied first. wake pulses, halt_req goes low, the wait is cancelled, watch_line is unchanged and the pending flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Arm command strobe |
| arm_vaddr | input | ADDR_W | Virtual address to monitor |
| wait_valid | input | 1 | Wait command strobe |
| wait_paddr | input | ADDR_W | Translated physical address of the monitored location |
| snoop_valid | input | 1 | Invalidation snoop strobe |
| snoop_addr | input | ADDR_W | Line-aligned invalidation address |
| halt_req | output | 1 | Request for the core to halt |
| wake | output | 1 | One-cycle wake pulse |
| watch_line | output | ADDR_W | Line address currently watched |
| probe_addr | output | ADDR_W | Virtual address of the probe access |
| probe_size | output | $clog2(PROBE_BYTES)+1 | Byte count of the probe access |

## Verification
All flag and address results are registered. halt_req, wake, watch_line and probe_addr therefore change at the first rising edge after a command or snoop. probe_size follows probe_addr through logic with no register. The bench drives every stimulus just after a falling edge and removes it at the next falling edge. It samples outputs at that same falling edge, which lies half a period after the one edge that updates them. Wake pulses are checked again one cycle later to show that they have ended. The probe-size rule is swept over every offset in a 64-byte line, and the bench computes each expected size from the offset.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef struct packed {
    logic armed;
    logic waiting;
    logic pending;
    logic halt;
  } mw_flags_t;
endpackage

// File: rtl/mw_line_math.sv
module mw_line_math #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int PROBE_BYTES = 8
) (
  input  logic [ADDR_W-1:0]              vaddr,
  input  logic [ADDR_W-1:0]              paddr,
  output logic [ADDR_W-1:0]              paddr_line,
  output logic [$clog2(PROBE_BYTES):0]   probe_size
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int RW    = OFF_W + 1;
  localparam int SZ_W  = $clog2(PROBE_BYTES) + 1;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES) - ADDR_W'(1));

  logic [RW-1:0] room;

  always_comb begin
    paddr_line = paddr & LINE_MASK;
    room       = RW'(LINE_BYTES) - {1'b0, vaddr[OFF_W-1:0]};
    if (room < RW'(PROBE_BYTES)) probe_size = SZ_W'(room);
    else                         probe_size = SZ_W'(PROBE_BYTES);
  end
endmodule

// File: rtl/mw_snoop_match.sv
module mw_snoop_match #(
  parameter int ADDR_W = 32
) (
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ADDR_W-1:0] watch_line,
  input  logic              armed,
  input  logic              waiting,
  output logic              hit
);
  always_comb begin
    hit = snoop_valid && armed && waiting && (snoop_addr == watch_line);
  end
endmodule

// File: rtl/mw_watch_ctrl.sv
module mw_watch_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic [ADDR_W-1:0] arm_vaddr,
  input  logic              wait_valid,
  input  logic [ADDR_W-1:0] wait_line,
  input  logic              snoop_valid,
  input  logic              hit,
  output mw_flags_t         flags,
  output logic [ADDR_W-1:0] vaddr_q,
  output logic [ADDR_W-1:0] line_q,
  output logic              wake_q
);
  mw_flags_t         flags_n;
  logic [ADDR_W-1:0] line_n;
  logic              line_en;
  logic              wait_take;
  logic              pend_eff;

  always_comb begin
    flags_n   = flags;
    line_n    = line_q;
    pend_eff  = flags.pending | hit;
    wait_take = wait_valid & ~pend_eff;
    if (hit) begin
      flags_n.waiting = 1'b0;
      flags_n.halt    = 1'b0;
      flags_n.pending = 1'b1;
    end
    if (arm_valid) begin
      flags_n.armed = 1'b1;
      line_n        = '0;
    end
    if (wait_valid) begin
      if (pend_eff) begin
        flags_n.pending = 1'b0;
      end else begin
        flags_n.waiting = 1'b1;
        flags_n.halt    = 1'b1;
        line_n          = wait_line;
      end
    end
    line_en = arm_valid | wait_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      wake_q <= 1'b0;
    end else begin
      flags  <= flags_n;
      wake_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vaddr_q <= '0;
    else if (arm_valid) vaddr_q <= arm_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_n;
  end

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  assert_wake_drops_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !flags.halt);
  assert_halt_from_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.halt) |-> $past(wait_valid));
  assert_wake_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !$past(wait_valid)) |-> flags.pending);
  assert_idle_snoop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && !(flags.armed && flags.waiting)) |=> !wake_q);
endmodule

// File: rtl/mw_watch_unit.sv
module mw_watch_unit
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int PROBE_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm_valid,
  input  logic [ADDR_W-1:0]             arm_vaddr,
  input  logic                          wait_valid,
  input  logic [ADDR_W-1:0]             wait_paddr,
  input  logic                          snoop_valid,
  input  logic [ADDR_W-1:0]             snoop_addr,
  output logic                          halt_req,
  output logic                          wake,
  output logic [ADDR_W-1:0]             watch_line,
  output logic [ADDR_W-1:0]             probe_addr,
  output logic [$clog2(PROBE_BYTES):0]  probe_size
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  mw_flags_t         flags;
  logic [ADDR_W-1:0] vaddr_q;
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] wait_line;
  logic              hit;
  logic              wake_q;

  mw_line_math #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PROBE_BYTES(PROBE_BYTES)
  ) u_math (
    .vaddr(vaddr_q), .paddr(wait_paddr),
    .paddr_line(wait_line), .probe_size(probe_size)
  );

  mw_snoop_match #(.ADDR_W(ADDR_W)) u_match (
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .watch_line(line_q),
    .armed(flags.armed), .waiting(flags.waiting), .hit(hit)
  );

  mw_watch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_vaddr(arm_vaddr),
    .wait_valid(wait_valid), .wait_line(wait_line),
    .snoop_valid(snoop_valid), .hit(hit),
    .flags(flags), .vaddr_q(vaddr_q), .line_q(line_q), .wake_q(wake_q)
  );

  assign halt_req   = flags.halt;
  assign wake       = wake_q;
  assign watch_line = line_q;
  assign probe_addr = vaddr_q;

  assert_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    watch_line[OFF_W-1:0] == '0);
  assert_probe_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_size != '0) && (probe_size <= ($clog2(PROBE_BYTES)+1)'(PROBE_BYTES)));
endmodule

// File: tb/tb_mw_watch_unit.sv
module tb_mw_watch_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_valid = 1'b0, wait_valid = 1'b0, snoop_valid = 1'b0;
  logic [AW-1:0] arm_vaddr = '0, wait_paddr = '0, snoop_addr = '0;
  logic          halt_req, wake;
  logic [AW-1:0] watch_line, probe_addr;
  logic [3:0]    probe_size;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  mw_watch_unit dut (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_vaddr(arm_vaddr),
    .wait_valid(wait_valid), .wait_paddr(wait_paddr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .halt_req(halt_req), .wake(wake), .watch_line(watch_line),
    .probe_addr(probe_addr), .probe_size(probe_size)
  );

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    arm_valid = 1'b0; wait_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic do_arm(logic [AW-1:0] a);
    arm_valid = 1'b1; arm_vaddr = a; tick();
  endtask
  task automatic do_wait(logic [AW-1:0] a);
    wait_valid = 1'b1; wait_paddr = a; tick();
  endtask
  task automatic do_snoop(logic [AW-1:0] a);
    snoop_valid = 1'b1; snoop_addr = a; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "halt", {31'b0, halt_req}, 0);
    chk("R1", "wake", {31'b0, wake}, 0);
    chk("R1", "line", watch_line, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // wait before arm: halts, but unarmed snoop is ignored
    do_wait(32'h0000_0047);
    chk("R3", "halt unarmed", {31'b0, halt_req}, 1);
    chk("R3", "line unarmed", watch_line, 32'h0000_0040);
    do_snoop(32'h0000_0040);
    chk("R8", "unarmed wake", {31'b0, wake}, 0);
    chk("R8", "unarmed halt", {31'b0, halt_req}, 1);

    // arm while waiting clears watched line to zero
    do_arm(32'h1000_0038);
    chk("R2", "probe addr", probe_addr, 32'h1000_0038);
    chk("R2", "line cleared", watch_line, 0);
    chk("R2", "halt kept", {31'b0, halt_req}, 1);
    do_snoop(32'h0000_0040);
    chk("R8", "old line", {31'b0, wake}, 0);
    do_snoop(32'h0000_0000);
    chk("R5", "wake on zero line", {31'b0, wake}, 1);
    chk("R5", "halt drop", {31'b0, halt_req}, 0);
    tick();
    chk("R7", "wake ended", {31'b0, wake}, 0);

    // pending from that wake cancels next wait
    do_wait(32'h2000_1234);
    chk("R6", "cancelled halt", {31'b0, halt_req}, 0);
    chk("R4", "line unchanged", watch_line, 0);
    do_wait(32'h2000_1234);
    chk("R4", "second wait halts", {31'b0, halt_req}, 1);
    chk("R3", "masked line", watch_line, 32'h2000_1200);

    do_snoop(32'h2000_1240);
    chk("R8", "other line wake", {31'b0, wake}, 0);
    chk("R8", "other line halt", {31'b0, halt_req}, 1);
    do_snoop(32'h2000_1204);
    chk("R8", "offset bits wake", {31'b0, wake}, 0);
    chk("R8", "offset line", watch_line, 32'h2000_1200);
    do_snoop(32'h2000_1200);
    chk("R5", "hit wake", {31'b0, wake}, 1);
    chk("R5", "hit halt", {31'b0, halt_req}, 0);
    do_snoop(32'h2000_1200);
    chk("R7", "no repeat wake", {31'b0, wake}, 0);
    chk("R8", "not waiting", {31'b0, halt_req}, 0);

    // consume pending, then same-cycle snoop and wait
    do_wait(32'h3000_0000);
    chk("R6", "cancel again", {31'b0, halt_req}, 0);
    do_wait(32'h3000_0080);
    chk("R3", "halt 3", {31'b0, halt_req}, 1);
    snoop_valid = 1'b1; snoop_addr = 32'h3000_0080;
    wait_valid = 1'b1; wait_paddr = 32'h4000_0100;
    tick();
    chk("R10", "wake", {31'b0, wake}, 1);
    chk("R10", "halt", {31'b0, halt_req}, 0);
    chk("R10", "line", watch_line, 32'h3000_0080);
    do_wait(32'h4000_0100);
    chk("R10", "pending cleared", {31'b0, halt_req}, 1);
    chk("R10", "new line", watch_line, 32'h4000_0100);

    // probe size sweep over every line offset
    for (int off = 0; off < 64; off++) begin
      int exp_sz;
      exp_sz = (64 - off < 8) ? 64 - off : 8;
      do_arm(32'h5000_0000 + off);
      chk("R9", "probe size", {28'b0, probe_size}, exp_sz);
      chk("R9", "probe addr", probe_addr, 32'h5000_0000 + off);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule